// File: doc/BRIEF.md
# Reset Cause Capture Register

This block remembers what caused the most recent system reset. It shows that cause in an 8-bit status register that software can only read. A power-on indication puts the register in a known state: only the power-on flag is set. Five internal reset requests each set their own flag when a new reset begins. The sources are watchdog, illegal opcode, illegal address, USB and low voltage.

The block pulls the external reset pin low for as long as any reset is active, and for a fixed hold time afterwards. It then releases the pin and, after a fixed settle delay, looks at the pin through a synchronizer. If something outside still holds the pin low, a pin flag is added to whatever causes are already recorded.

A read returns the current flags, and the register clears on the next clock edge. Software reads it once after boot to find out why the system restarted.

Top module: `rst_cause_capture`

## Requirements
- R1: The flag bits are laid out as follows: bit 7 is power-on, bit 6 is pin, and bits 5 to 1 follow `src_req_i[4:0]` in order (bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 2 USB, bit 1 low voltage). Bit 0 always reads 0.
- R2: While `por_i` is high, the register reads 8'h80 and `pin_low_o` is 1.
- R3: `rd_data_o` shows the flags before the clear during the cycle in which `rd_i` is high. The edge that ends that cycle clears every flag, unless a reset event lands on that same edge.
- R4: `pin_low_o` is 1 from the edge after any request is seen until the 64th clock edge at which no request is present, counted from the last request (or from the release of `por_i`). It then drops to 0.
- R5: The pin passes through a two-flop synchronizer and is sampled on the 32nd edge after the edge that released it. If it is low there, bit 6 is set on top of the other flags, and not before that edge.
- R6: If the pin is high at the sample point, bit 6 stays 0.
- R7: A request seen while no reset hold is in progress clears all earlier flags, power-on and pin included. It then sets the flag of every cause present at that edge, so causes that arrive together are all kept.
- R8: Further requests seen while the hold is in progress add their flags to the ones already set.
- R9: A request during the 32-cycle settle window starts a new reset. The pending pin sample is dropped, and the earlier flags are replaced.
- R10: Bit 7 never goes from 0 to 1 except through `por_i`, so a 0 there means the register has been read since power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous |
| src_req_i | input | 5 | Internal reset requests: [4] watchdog, [3] illegal opcode, [2] illegal address, [1] USB, [0] low voltage |
| pin_i | input | 1 | Level of the external reset pin |
| rd_i | input | 1 | Register read strobe |
| pin_low_o | output | 1 | 1 = pull the external reset pin low |
| rd_data_o | output | 8 | Status register contents |

## Verification
The bench measures the hold exactly. A count that is off by one, or one that restarts from the first request instead of the last, shows up as a release one cycle early or late. It watches the pin flag on the edge before the sample point and on the sample point itself, so an early sample, or one that skips the synchronizer, is caught.

It drives requests that arrive one after another inside a hold, and a request that lands in the settle window. A design that replaced flags inside the hold would lose a cause. A design that kept the stale sample would report a pin event that did not happen. Reads check both the pre-clear data and the cleared value, and a power-on with the pin held low shows whether the pin flag truly sits on top of the power-on flag.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int FLAG_W  = 8;
  localparam int NUM_SRC = 5;
  localparam int POR_B   = 7;
  localparam int PIN_B   = 6;
  localparam int SRC_LSB = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_SETL = 2'd2
  } seq_state_e;

  // Causes land at bits SRC_LSB.. upward; all other bits stay zero.
  function automatic logic [FLAG_W-1:0] place_causes(input logic [NUM_SRC-1:0] m);
    logic [FLAG_W-1:0] v;
    v = '0;
    v[SRC_LSB +: NUM_SRC] = m;
    return v;
  endfunction

  function automatic logic [FLAG_W-1:0] power_on_value();
    logic [FLAG_W-1:0] v;
    v = '0;
    v[POR_B] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) ff <= '0;
    else       ff <= {ff[STAGES-2:0], d_i};
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/rcc_seq.sv
module rcc_seq
  import rcc_pkg::*;
#(
  parameter int HOLD_CYC = 64,
  parameter int SAMP_CYC = 32
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic any_req_i,
  output logic start_o,
  output logic hold_o,
  output logic fire_o
);
  localparam int MAXC  = (HOLD_CYC > SAMP_CYC) ? HOLD_CYC : SAMP_CYC;
  localparam int CNT_W = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(SAMP_CYC - 1);

  seq_state_e       st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      st  <= ST_HOLD;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (any_req_i) begin
            st  <= ST_HOLD;
            cnt <= '0;
          end
        end
        ST_HOLD: begin
          if (any_req_i)              cnt <= '0;
          else if (cnt == HOLD_LAST) begin
            st  <= ST_SETL;
            cnt <= '0;
          end else                    cnt <= cnt + 1'b1;
        end
        ST_SETL: begin
          if (any_req_i) begin
            st  <= ST_HOLD;
            cnt <= '0;
          end else if (cnt == SAMP_LAST) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          st  <= ST_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign start_o = any_req_i && (st != ST_HOLD);
  assign hold_o  = (st == ST_HOLD);
  assign fire_o  = (st == ST_SETL) && !any_req_i && (cnt == SAMP_LAST);
endmodule

// File: rtl/rcc_flags.sv
module rcc_flags
  import rcc_pkg::*;
(
  input  logic               clk_i,
  input  logic               por_i,
  input  logic               rd_i,
  input  logic               start_i,
  input  logic               hold_i,
  input  logic               fire_i,
  input  logic [NUM_SRC-1:0] causes_i,
  input  logic               pin_sync_i,
  output logic [FLAG_W-1:0]  flags_o
);
  logic [FLAG_W-1:0] nxt;

  always_comb begin
    nxt = flags_o;
    if (rd_i)         nxt = '0;
    if (start_i)      nxt = place_causes(causes_i);
    else if (hold_i)  nxt = nxt | place_causes(causes_i);
    if (fire_i && !pin_sync_i) nxt[PIN_B] = 1'b1;
    nxt[0] = 1'b0;
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) flags_o <= power_on_value();
    else       flags_o <= nxt;
  end
endmodule

// File: rtl/rst_cause_capture.sv
module rst_cause_capture
  import rcc_pkg::*;
#(
  parameter int HOLD_CYC    = 64,
  parameter int SAMP_CYC    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               por_i,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               pin_i,
  input  logic               rd_i,
  output logic               pin_low_o,
  output logic [FLAG_W-1:0]  rd_data_o
);
  logic any_req_w;
  logic start_w;
  logic hold_w;
  logic fire_w;
  logic pin_sync_w;

  assign any_req_w = |src_req_i;

  rcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (por_i),
    .d_i   (pin_i),
    .q_o   (pin_sync_w)
  );

  rcc_seq #(.HOLD_CYC(HOLD_CYC), .SAMP_CYC(SAMP_CYC)) u_seq (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .any_req_i (any_req_w),
    .start_o   (start_w),
    .hold_o    (hold_w),
    .fire_o    (fire_w)
  );

  rcc_flags u_flags (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .rd_i       (rd_i),
    .start_i    (start_w),
    .hold_i     (hold_w),
    .fire_i     (fire_w),
    .causes_i   (src_req_i),
    .pin_sync_i (pin_sync_w),
    .flags_o    (rd_data_o)
  );

  assign pin_low_o = por_i | hold_w;
endmodule

// File: rtl/rcc_chk.sv
module rcc_chk
  import rcc_pkg::*;
#(
  parameter int HOLD_CYC = 64,
  parameter int SAMP_CYC = 32
) (
  input logic               clk_i,
  input logic               por_i,
  input logic [NUM_SRC-1:0] src_req_i,
  input logic               rd_i,
  input logic               pin_low_o,
  input logic [FLAG_W-1:0]  rd_data_o,
  input logic               hold_w,
  input logic               fire_w
);
  localparam int QW = $clog2(HOLD_CYC + 2) + 1;
  localparam int RW = $clog2(SAMP_CYC + 1) + 1;

  logic [QW-1:0] quiet_cnt;
  logic [RW-1:0] rel_cnt;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)                              quiet_cnt <= '0;
    else if (|src_req_i)                    quiet_cnt <= '0;
    else if (quiet_cnt != QW'(HOLD_CYC + 1)) quiet_cnt <= quiet_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)                          rel_cnt <= '0;
    else if (pin_low_o)                 rel_cnt <= '0;
    else if (rel_cnt != RW'(SAMP_CYC))  rel_cnt <= rel_cnt + 1'b1;
  end

  a_r1_bit0_zero: assert property (@(posedge clk_i) disable iff (por_i)
    rd_data_o[0] == 1'b0);

  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (por_i)
    (rd_i && !(|src_req_i) && !hold_w && !fire_w) |=> (rd_data_o == '0));

  a_r4_req_drives_pin: assert property (@(posedge clk_i) disable iff (por_i)
    (|src_req_i) |=> pin_low_o);

  a_r4_hold_len: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(pin_low_o) |-> (quiet_cnt == QW'(HOLD_CYC)));

  a_r5_sample_point: assert property (@(posedge clk_i) disable iff (por_i)
    fire_w |-> (rel_cnt == RW'(SAMP_CYC - 1)));

  a_r5_pin_only_at_sample: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(rd_data_o[PIN_B]) |-> $past(fire_w));

  a_r10_por_no_rise: assert property (@(posedge clk_i) disable iff (por_i)
    !$rose(rd_data_o[POR_B]));
endmodule

bind rst_cause_capture rcc_chk #(.HOLD_CYC(HOLD_CYC), .SAMP_CYC(SAMP_CYC)) chk_i (
  .clk_i     (clk_i),
  .por_i     (por_i),
  .src_req_i (src_req_i),
  .rd_i      (rd_i),
  .pin_low_o (pin_low_o),
  .rd_data_o (rd_data_o),
  .hold_w    (hold_w),
  .fire_w    (fire_w)
);

// File: tb/rst_cause_capture_tb.sv
module rst_cause_capture_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HOLD = 64;
  localparam int  SAMP = 32;

  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic [4:0] src_req_i = '0;
  logic       rd_i = 1'b0;
  logic       ext_low = 1'b0;
  logic       pin_i;
  logic       pin_low_o;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain pin: low if this block or something outside pulls it
  assign pin_i = ~(pin_low_o | ext_low);

  rst_cause_capture dut_i (
    .clk_i     (clk),
    .por_i     (por_i),
    .src_req_i (src_req_i),
    .pin_i     (pin_i),
    .rd_i      (rd_i),
    .pin_low_o (pin_low_o),
    .rd_data_o (rd_data_o)
  );

  function automatic logic [7:0] exp_flags(input bit por, input bit pin, input logic [4:0] m);
    return {por, pin, m, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] m, input int len);
    src_req_i = m;
    repeat (len) @(negedge clk);
    src_req_i = '0;
  endtask

  // called at the negedge where requests (or por) were just dropped
  task automatic wait_release();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (pin_low_o && n < 200);
    chk(n == HOLD, "R4 hold length", 8'(n), 8'(HOLD));
  endtask

  task automatic check_sample(input logic [7:0] base, input bit ext);
    repeat (SAMP - 1) @(negedge clk);
    chk(rd_data_o == base, "R5 no early pin flag", rd_data_o, base);
    @(negedge clk);
    if (ext) chk(rd_data_o == (base | 8'h40), "R5 pin flag set", rd_data_o, base | 8'h40);
    else     chk(rd_data_o == base, "R6 pin flag clear", rd_data_o, base);
    ext_low = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] exp);
    rd_i = 1'b1;
    #1;
    chk(rd_data_o == exp, "R3 pre-clear data", rd_data_o, exp);
    @(negedge clk);
    rd_i = 1'b0;
    #1;
    chk(rd_data_o == 8'h00, "R3 cleared after read", rd_data_o, 8'h00);
  endtask

  task automatic run_reset(input logic [4:0] m1, input int len, input logic [4:0] m2,
                           input int gap, input bit ext);
    ext_low = ext;
    pulse(m1, len);
    if (m2 != 0) begin
      repeat (gap) @(negedge clk);
      pulse(m2, 1);
    end
    wait_release();
    check_sample(exp_flags(1'b0, 1'b0, m1 | m2), ext);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R2: power-on state
    repeat (3) @(negedge clk);
    chk(rd_data_o == 8'h80, "R2 power-on value", rd_data_o, 8'h80);
    chk(pin_low_o == 1'b1, "R2 pin low in power-on", {7'b0, pin_low_o}, 8'h01);
    por_i = 1'b0;
    wait_release();
    check_sample(8'h80, 1'b0);
    do_read(8'h80);
    do_read(8'h00);                       // R10: power-on flag stays cleared

    // R7: all causes together
    run_reset(5'h1F, 1, 5'h00, 0, 1'b1);
    do_read(8'h7E);

    // R1: each cause lands on its own bit
    for (int i = 0; i < 5; i++) begin
      run_reset(5'(1 << i), 3, 5'h00, 0, 1'b0);
      do_read(8'(2 << i));
    end

    // R7: a new reset discards earlier flags, pin included
    run_reset(5'h04, 2, 5'h00, 0, 1'b1);
    run_reset(5'h10, 2, 5'h00, 0, 1'b0);
    do_read(exp_flags(1'b0, 1'b0, 5'h10));

    // R8: a second cause inside the hold accumulates
    run_reset(5'h01, 2, 5'h08, 20, 1'b0);
    do_read(exp_flags(1'b0, 1'b0, 5'h09));

    // R9: a request in the settle window restarts and drops the pending sample
    ext_low = 1'b1;
    pulse(5'h02, 2);
    wait_release();
    repeat (10) @(negedge clk);
    ext_low = 1'b0;
    pulse(5'h10, 1);
    wait_release();
    check_sample(exp_flags(1'b0, 1'b0, 5'h10), 1'b0);
    do_read(exp_flags(1'b0, 1'b0, 5'h10));

    // R2, R5: power-on with the pin held low outside
    @(negedge clk);
    por_i = 1'b1;
    ext_low = 1'b1;
    repeat (2) @(negedge clk);
    chk(rd_data_o == 8'h80, "R2 power-on value again", rd_data_o, 8'h80);
    por_i = 1'b0;
    wait_release();
    check_sample(8'h80, 1'b1);
    do_read(8'hC0);

    // random mix
    for (int it = 0; it < 16; it++) begin
      logic [4:0] m1 = 5'($urandom_range(1, 31));
      logic [4:0] m2 = ($urandom_range(0, 1) != 0) ? 5'($urandom_range(1, 31)) : 5'h00;
      int len = $urandom_range(1, 6);
      int gap = $urandom_range(1, 50);
      bit ext = 1'($urandom_range(0, 1));
      run_reset(m1, len, m2, gap, ext);
      do_read(exp_flags(1'b0, ext, m1 | m2));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule